// File: doc/BRIEF.md
# Scanning ADC Sequencer with Result Register

This block is the digital side of a multi-channel successive-approximation ADC. Software writes one control word. It holds an 8-bit channel-select mask, an ADC clock divider, a scan (burst) enable and a 3-bit trigger field. The block then issues one-cycle start pulses to an external conversion engine and tags each pulse with a channel number. When the engine reports a finished 10-bit code, the block stores the code in a single readable result word, together with the channel number, a completion flag and a lost-result flag.

A single conversion runs on the lowest selected channel. It begins at once, or it waits for a shared trigger strobe, so that two instances can start on the same cycle. In scan mode the block converts without pause and walks upward through the selected channels, returning to the lowest one after the highest. Reading the result word consumes the flags. A control write that arrives during a conversion marks the result word as complete. If the new control word asks for a conversion, the block abandons the running one and starts again.

Top module: `adc_scan_top`

## Requirements
- R1: The control word layout is: mask in bits 7:0 (bit n selects channel n), divider in bits 15:8, scan enable in bit 16, and trigger in bits 19:17. Trigger 0 means no trigger, 1 means convert now and 2 means wait for `globalStart`.
- R2: The result word layout is: code in bits 15:6, channel in bits 26:24, lost flag in bit 30 and complete flag in bit 31. All other bits read 0, and the whole word is 0 after reset.
- R3: The ADC clock enable fires every divider+1 bus cycles, counted from the clock edge of the control write. Each `convStart` is a one-cycle pulse on that enable. A conversion requested by a write pulses exactly divider+1 cycles after the write edge.
- R4: With scan off and trigger 1, exactly one conversion runs, on the lowest selected channel.
- R5: With scan on and trigger 0, conversions repeat back to back. They start at the lowest selected channel, move to the next higher selected channel each time, and wrap from the highest to the lowest.
- R6: With scan on and a nonzero trigger, or with an all-zero mask, no conversion starts.
- R7: A completed conversion stores its code and channel and sets the complete flag.
- R8: A read returns the word as it was before the read and then clears the complete and lost flags.
- R9: The lost flag is set when the result of a conversion started in scan mode replaces a result that was not read. A conversion started outside scan mode leaves the flag clear.
- R10: A control write clears the complete flag when no conversion is running. If a conversion is running, the write sets the flag instead. If the new word requests a conversion, the running one is abandoned (its late completion is ignored) and a new one starts on the lowest selected channel.
- R11: Turning scan off during a conversion lets that conversion finish and update the result word. No further conversion starts.
- R12: With scan off and trigger 2, nothing starts until a `globalStart` pulse arrives. The pulse starts one conversion on the lowest selected channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control word write strobe |
| ctrlWrData | input | 20 | Control word |
| dataRd | input | 1 | Result word read strobe |
| dataRdData | output | 32 | Result word |
| globalStart | input | 1 | Shared trigger strobe |
| convStart | output | 1 | Start pulse to conversion engine |
| convChan | output | 3 | Channel for the engine |
| convDone | input | 1 | Engine completion pulse |
| convCode | input | 10 | Engine result code |

## Verification
A wrong scan pointer shows on `convChan` at the very next start pulse, one ADC clock after the preceding completion. So the bench compares every logged start channel against a scan order it computes itself. A stale busy or pending flag shows up as a missing or extra start pulse. The bench watches long idle windows for these after stops, blocked configurations and abandoned conversions. Flag errors show in the result word on the cycle after a capture, a read or a write, and the bench samples the word exactly there.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  // Control word fields
  localparam int MASK_LSB  = 0;
  localparam int DIV_LSB   = 8;
  localparam int BURST_BIT = 16;
  localparam int TRIG_LSB  = 17;
  localparam int TRIG_W    = 3;
  localparam int CTRL_W    = TRIG_LSB + TRIG_W;

  localparam logic [TRIG_W-1:0] TRIG_NONE   = 3'd0;
  localparam logic [TRIG_W-1:0] TRIG_NOW    = 3'd1;
  localparam logic [TRIG_W-1:0] TRIG_GLOBAL = 3'd2;

  // Result word fields
  localparam int CHAN_W    = 3;
  localparam int RES_W     = 10;
  localparam int RES_LSB   = 6;
  localparam int RCHAN_LSB = 24;
  localparam int LOST_BIT  = 30;
  localparam int DONE_BIT  = 31;
  localparam int WORD_W    = 32;

  // Strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic [CHAN_W-1:0] chan;
    logic              setDone;
    logic              clrDone;
    logic              scanResult;
  } dpCmd_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              globalStart,
  input  logic              convDone,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  output dpCmd_t            cmd
);

  logic [NUM_CH-1:0] maskQ;
  logic [DIV_W-1:0]  divQ;
  logic              burstQ;
  logic [TRIG_W-1:0] trigQ;
  logic [DIV_W-1:0]  divCnt;
  logic              pendQ, busyQ, armedQ, scanQ;
  logic [CHAN_W-1:0] chanQ;

  logic [NUM_CH-1:0] wrMask;
  logic              wrBurst;
  logic [TRIG_W-1:0] wrTrig;
  logic              wrReq, wrArm, tick, capture, scanGo, globalGo;

  function automatic logic [CHAN_W-1:0] lowestSet(input logic [NUM_CH-1:0] m);
    logic [CHAN_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = CHAN_W'(i);
    end
    return r;
  endfunction

  function automatic logic [CHAN_W-1:0] nextSet(input logic [NUM_CH-1:0] m,
                                                input logic [CHAN_W-1:0] cur);
    logic [CHAN_W-1:0] r;
    logic found;
    r = lowestSet(m);
    found = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!found && (i > int'(cur)) && m[i]) begin
        r = CHAN_W'(i);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  always_comb begin
    wrMask   = ctrlWrData[MASK_LSB +: NUM_CH];
    wrBurst  = ctrlWrData[BURST_BIT];
    wrTrig   = ctrlWrData[TRIG_LSB +: TRIG_W];
    wrReq    = (wrMask != '0) &&
               ((wrBurst && wrTrig == TRIG_NONE) || (!wrBurst && wrTrig == TRIG_NOW));
    wrArm    = (wrMask != '0) && !wrBurst && (wrTrig == TRIG_GLOBAL);
    tick     = (divCnt == divQ);
    convStart = pendQ && tick && !busyQ;
    capture  = convDone && busyQ && !ctrlWr;
    scanGo   = burstQ && (trigQ == TRIG_NONE) && (maskQ != '0);
    globalGo = armedQ && globalStart && !busyQ && !pendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      divQ   <= '0;
      burstQ <= 1'b0;
      trigQ  <= TRIG_NONE;
      divCnt <= '0;
      pendQ  <= 1'b0;
      busyQ  <= 1'b0;
      armedQ <= 1'b0;
      scanQ  <= 1'b0;
      chanQ  <= '0;
    end else if (ctrlWr) begin
      maskQ  <= wrMask;
      divQ   <= ctrlWrData[DIV_LSB +: DIV_W];
      burstQ <= wrBurst;
      trigQ  <= wrTrig;
      divCnt <= '0;
      armedQ <= wrArm;
      pendQ  <= wrReq;
      if (wrReq) begin
        busyQ <= 1'b0;
        chanQ <= lowestSet(wrMask);
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (convStart) begin
        pendQ <= 1'b0;
        busyQ <= 1'b1;
        scanQ <= burstQ;
      end else if (capture) begin
        busyQ <= 1'b0;
        if (scanGo) begin
          pendQ <= 1'b1;
          chanQ <= nextSet(maskQ, chanQ);
        end
      end else if (globalGo) begin
        pendQ  <= 1'b1;
        armedQ <= 1'b0;
        chanQ  <= lowestSet(maskQ);
      end
    end
  end

  assign convChan = chanQ;

  always_comb begin
    cmd.capture    = capture;
    cmd.chan       = chanQ;
    cmd.setDone    = ctrlWr && busyQ;
    cmd.clrDone    = ctrlWr && !busyQ;
    cmd.scanResult = scanQ;
  end

  // R3: start is a single-cycle pulse unless a restart write intervenes
  a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (convStart && !ctrlWr) |=> !convStart);
  // R5: every start names a selected channel
  a_r5_start_selected: assert property (@(posedge clk) disable iff (!rstN)
    convStart |-> maskQ[chanQ]);
  // R6: scan with a nonzero trigger never starts
  a_r6_blocked_scan: assert property (@(posedge clk) disable iff (!rstN)
    (burstQ && trigQ != TRIG_NONE) |-> !convStart);
  // R6: empty mask never starts
  a_r6_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !convStart);
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [RES_W-1:0]  convCode,
  input  logic              dataRd,
  output logic [WORD_W-1:0] dataRdData
);

  logic [RES_W-1:0]  resQ;
  logic [CHAN_W-1:0] chanQ;
  logic              doneQ, lostQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ  <= '0;
      chanQ <= '0;
      doneQ <= 1'b0;
      lostQ <= 1'b0;
    end else if (cmd.capture) begin
      resQ  <= convCode;
      chanQ <= cmd.chan;
      doneQ <= 1'b1;
      lostQ <= cmd.scanResult && !dataRd && (doneQ || lostQ);
    end else begin
      if (cmd.setDone)      doneQ <= 1'b1;
      else if (cmd.clrDone) doneQ <= 1'b0;
      else if (dataRd)      doneQ <= 1'b0;
      if (dataRd)           lostQ <= 1'b0;
    end
  end

  always_comb begin
    dataRdData = '0;
    dataRdData[RES_LSB +: RES_W]    = resQ;
    dataRdData[RCHAN_LSB +: CHAN_W] = chanQ;
    dataRdData[LOST_BIT]            = lostQ;
    dataRdData[DONE_BIT]            = doneQ;
  end

  // R7: a capture leaves the complete flag set
  a_r7_done_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    cmd.capture |=> doneQ);
  // R8: a plain read clears both flags
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !cmd.capture && !cmd.setDone) |=> (!doneQ && !lostQ));
  // R9: lost flag only rises from a scan-mode result
  a_r9_lost_scan_only: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lostQ) |-> $past(cmd.scanResult));
endmodule

// File: rtl/adc_scan_top.sv
module adc_scan_top
  import adc_scan_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              dataRd,
  output logic [WORD_W-1:0] dataRdData,
  input  logic              globalStart,
  output logic              convStart,
  output logic [CHAN_W-1:0] convChan,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convCode
);

  dpCmd_t cmd;

  adc_scan_ctrl #(.NUM_CH(NUM_CH), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .globalStart(globalStart), .convDone(convDone),
    .convStart(convStart), .convChan(convChan), .cmd(cmd)
  );

  adc_scan_dp dp_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .convCode(convCode),
    .dataRd(dataRd), .dataRdData(dataRdData)
  );
endmodule

// File: tb/adc_scan_top_tb_top.sv
module adc_scan_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN, ctrlWr, dataRd, globalStart, convStart, convDone;
  logic [19:0] ctrlWrData;
  logic [31:0] dataRdData;
  logic [2:0]  convChan;
  logic [9:0]  convCode;

  always #10 clk = ~clk;  // 50 MHz

  adc_scan_top dut_i (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlWrData(ctrlWrData),
    .dataRd(dataRd), .dataRdData(dataRdData), .globalStart(globalStart),
    .convStart(convStart), .convChan(convChan), .convDone(convDone),
    .convCode(convCode)
  );

  int nChecks = 0, nFails = 0;
  int cycleCnt = 0, wrCyc = 0, engDiv = 0, engCount = 0;
  int startCnt = 0, doneCnt = 0;
  int startChanLog[64];
  int startCycLog[64];
  bit engBusy = 0, finished = 0;
  int engChan = 0;
  int lastChan = 0, lastCode = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lowBit(input int m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nextBit(input int m, input int cur);
    for (int i = cur + 1; i < 8; i++) if (m[i]) return i;
    return lowBit(m);
  endfunction

  // Behavioural conversion engine: 11 ADC clocks per conversion
  initial begin
    convDone = 1'b0;
    convCode = '0;
    forever begin
      @(posedge clk);
      #2;
      cycleCnt++;
      convDone = 1'b0;
      if (rstN !== 1'b1) begin
        engBusy = 0;
        continue;
      end
      if (convStart) begin
        if (startCnt < 64) begin
          startChanLog[startCnt] = int'(convChan);
          startCycLog[startCnt]  = cycleCnt;
        end
        startCnt++;
        engBusy  = 1;
        engChan  = int'(convChan);
        engCount = 11 * (engDiv + 1);
      end else if (engBusy) begin
        engCount--;
        if (engCount == 0) begin
          convDone = 1'b1;
          convCode = 10'($urandom);
          lastCode = int'(convCode);
          lastChan = engChan;
          engBusy  = 0;
          doneCnt++;
        end
      end
    end
  end

  task automatic wrCtrl(input int mask, input int div, input bit burst, input int trig);
    @(negedge clk);
    ctrlWrData = 20'(mask | (div << 8) | (int'(burst) << 16) | (trig << 17));
    ctrlWr = 1'b1;
    engDiv = div;
    wrCyc  = cycleCnt;
    @(negedge clk);
    ctrlWr = 1'b0;
  endtask

  task automatic rdWord(output logic [31:0] v);
    @(negedge clk);
    v = dataRdData;
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
  endtask

  task automatic waitDone(input int target);
    while (doneCnt < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic waitStart(input int target);
    while (startCnt < target) @(negedge clk);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "WATCHDOG", "run did not finish", 0, 1);
    finish();
  end

  initial begin
    logic [31:0] v;
    int s0, d0, expCh, mask, div;
    void'($urandom(32'h5EED_0042));
    rstN = 1'b0; ctrlWr = 1'b0; ctrlWrData = '0; dataRd = 1'b0; globalStart = 1'b0;
    repeat (4) @(negedge clk);
    check(dataRdData == 32'h0, "R2", "reset result word", int'(dataRdData), 0);
    check(convStart == 1'b0, "R3", "reset start", int'(convStart), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R4 R7 R3: single immediate conversion, mask 0x24, divider 1
    s0 = startCnt; d0 = doneCnt;
    wrCtrl(8'h24, 1, 0, 1);
    waitStart(s0 + 1);
    check(startCycLog[s0] - wrCyc == 2, "R3", "first start delay", startCycLog[s0] - wrCyc, 2);
    check(startChanLog[s0] == 2, "R1 R4", "single channel", startChanLog[s0], 2);
    waitDone(d0 + 1);
    check(dataRdData[31] == 1'b1, "R7", "done flag", int'(dataRdData[31]), 1);
    check(int'(dataRdData[26:24]) == 2, "R7", "stored channel", int'(dataRdData[26:24]), 2);
    check(int'(dataRdData[15:6]) == lastCode, "R7", "stored code", int'(dataRdData[15:6]), lastCode);
    check((dataRdData & 32'h38FF_003F) == 0, "R2", "reserved bits", int'(dataRdData & 32'h38FF_003F), 0);
    check(dataRdData[30] == 1'b0, "R9", "lost after single", int'(dataRdData[30]), 0);
    repeat (60) @(negedge clk);
    check(startCnt == s0 + 1, "R4", "single start count", startCnt - s0, 1);

    // R8: read returns pre-read word, then flags clear
    rdWord(v);
    check(v[31] == 1'b1, "R8", "read sees done", int'(v[31]), 1);
    check(dataRdData[31] == 1'b0, "R8", "done after read", int'(dataRdData[31]), 0);

    // R9 R10: two unread single conversions, idle write clears done
    d0 = doneCnt;
    wrCtrl(8'h01, 0, 0, 1);
    waitDone(d0 + 1);
    wrCtrl(8'h01, 0, 0, 1);
    check(dataRdData[31] == 1'b0, "R10", "idle write clears done", int'(dataRdData[31]), 0);
    waitDone(d0 + 2);
    check(dataRdData[30] == 1'b0, "R9", "no lost flag outside scan", int'(dataRdData[30]), 0);
    check(dataRdData[31] == 1'b1, "R7", "done after second single", int'(dataRdData[31]), 1);
    rdWord(v);

    // R5 R3: scan mask 0x92 divider 2 -> 1,4,7,1,4
    s0 = startCnt;
    wrCtrl(8'h92, 2, 1, 0);
    waitStart(s0 + 5);
    expCh = 1;
    for (int k = 0; k < 5; k++) begin
      check(startChanLog[s0 + k] == expCh, "R5", "scan order", startChanLog[s0 + k], expCh);
      check((startCycLog[s0 + k] - wrCyc) % 3 == 0, "R3", "start on ADC clock",
            (startCycLog[s0 + k] - wrCyc) % 3, 0);
      expCh = nextBit(8'h92, expCh);
    end
    // R11 R10: stop scan mid-conversion
    d0 = doneCnt;
    wrCtrl(8'h92, 2, 0, 0);
    check(dataRdData[31] == 1'b1, "R10", "busy write sets done", int'(dataRdData[31]), 1);
    s0 = startCnt;
    waitDone(d0 + 1);
    check(int'(dataRdData[26:24]) == 4, "R11", "final channel", int'(dataRdData[26:24]), 4);
    check(int'(dataRdData[15:6]) == lastCode, "R11", "final code", int'(dataRdData[15:6]), lastCode);
    check(dataRdData[30] == 1'b1, "R9", "lost flag after unread scan", int'(dataRdData[30]), 1);
    repeat (150) @(negedge clk);
    check(startCnt == s0, "R11", "no start after stop", startCnt - s0, 0);
    rdWord(v);
    check(v[30] == 1'b1, "R8", "read sees lost", int'(v[30]), 1);
    check(dataRdData[31:30] == 2'b00, "R8", "flags after read", int'(dataRdData[31:30]), 0);

    // R6: blocked configurations
    s0 = startCnt;
    wrCtrl(8'h0F, 0, 1, 3);
    repeat (200) @(negedge clk);
    check(startCnt == s0, "R6", "scan with trigger", startCnt - s0, 0);
    wrCtrl(8'h00, 0, 1, 0);
    repeat (200) @(negedge clk);
    check(startCnt == s0, "R6", "empty mask", startCnt - s0, 0);
    check(dataRdData[31] == 1'b0, "R6", "no result from blocked", int'(dataRdData[31]), 0);

    // R10: restart during a running scan conversion
    s0 = startCnt; d0 = doneCnt;
    wrCtrl(8'h30, 3, 1, 0);
    waitStart(s0 + 1);
    repeat (5) @(negedge clk);
    wrCtrl(8'h0C, 0, 0, 1);
    check(dataRdData[31] == 1'b1, "R10", "restart write sets done", int'(dataRdData[31]), 1);
    waitStart(s0 + 2);
    check(startChanLog[s0 + 1] == 2, "R10", "restart channel", startChanLog[s0 + 1], 2);
    waitDone(d0 + 1);
    check(int'(dataRdData[26:24]) == 2, "R10", "restart result channel", int'(dataRdData[26:24]), 2);
    check(int'(dataRdData[15:6]) == lastCode, "R10", "restart code", int'(dataRdData[15:6]), lastCode);
    repeat (60) @(negedge clk);
    check(startCnt == s0 + 2, "R10", "restart start count", startCnt - s0, 2);
    rdWord(v);

    // R12: wait for shared trigger
    s0 = startCnt; d0 = doneCnt;
    wrCtrl(8'h40, 0, 0, 2);
    repeat (50) @(negedge clk);
    check(startCnt == s0, "R12", "armed without trigger", startCnt - s0, 0);
    @(negedge clk); globalStart = 1'b1;
    @(negedge clk); globalStart = 1'b0;
    waitStart(s0 + 1);
    check(startChanLog[s0] == 6, "R12", "triggered channel", startChanLog[s0], 6);
    waitDone(d0 + 1);
    check(int'(dataRdData[26:24]) == 6, "R12", "triggered result", int'(dataRdData[26:24]), 6);
    rdWord(v);

    // Random mix of single and scan runs
    for (int it = 0; it < 12; it++) begin
      mask = int'($urandom % 255) + 1;
      div  = int'($urandom % 4);
      s0 = startCnt; d0 = doneCnt;
      if (it % 2 == 1) begin
        wrCtrl(mask, div, 0, 1);
        waitDone(d0 + 1);
        check(int'(dataRdData[26:24]) == lowBit(mask), "R4", "random single channel",
              int'(dataRdData[26:24]), lowBit(mask));
        check(int'(dataRdData[15:6]) == lastCode, "R7", "random single code",
              int'(dataRdData[15:6]), lastCode);
      end else begin
        wrCtrl(mask, div, 1, 0);
        waitStart(s0 + 4);
        expCh = lowBit(mask);
        for (int k = 0; k < 4; k++) begin
          check(startChanLog[s0 + k] == expCh, "R5", "random scan order",
                startChanLog[s0 + k], expCh);
          expCh = nextBit(mask, expCh);
        end
        d0 = doneCnt;
        wrCtrl(mask, div, 0, 0);
        waitDone(d0 + 1);
        check(int'(dataRdData[26:24]) == lastChan, "R11", "random stop channel",
              int'(dataRdData[26:24]), lastChan);
      end
      rdWord(v);
    end

    finish();
  end
endmodule